// File: doc/BRIEF.md
# Cartridge Bank-Switching Address Mapper

This block sits between an 8-bit console's buses and the cartridge ROMs. CPU writes into the upper half of the CPU address space program a bank-select byte and eight bank bytes. From those registers the block turns a CPU program address into a program ROM address, and a PPU pattern-table address into a character ROM address. The translation is purely combinational from the current register contents.

The mode bits that would swap the windows are locked to zero, so the window layout never changes. The two 2 KB pattern windows draw from the lower half of character ROM. The four 1 KB windows always draw from the upper half, because bank bit 6 is forced high for them.

Nametable mirroring is a static configuration input passed straight through, and the interrupt request output never asserts. A parallel 72-bit port lets the nine register bytes be read out at any time and loaded back in one cycle.

Top module: `bankmap_top`

## Requirements
- R1: A write with `cpu_wr` high and `cpu_addr[15]`=1 is decoded on `cpu_addr[0]` alone. When bit 0 is 0 it writes bank-select. When bit 0 is 1 it writes bank byte Rn, where n is bank-select bits 2:0. Every other address bit is ignored, and a write with `cpu_addr[15]`=0 changes no register.
- R2: Bank-select keeps only the low 6 bits of the written byte. Bits 7:6 read back as zero and never alter the window layout.
- R3: PRG windows: $8000–$9FFF uses R6, $A000–$BFFF uses R7, $C000–$DFFF uses the second-last bank and $E000–$FFFF uses the last bank. `prg_rom_addr` is {bank, `cpu_addr[12:0]`}.
- R4: Pattern $0000–$07FF uses R0 and $0800–$0FFF uses R1. In each case the bank is (Rn AND 0x3E) with `ppu_addr[10]` as the low bit. `chr_rom_addr` is {bank, `ppu_addr[9:0]`}.
- R5: Pattern $1000, $1400, $1800 and $1C00 (1 KB each) use R2, R3, R4 and R5. The bank is Rn OR 0x40.
- R6: Bank numbers wrap modulo 2^`PRG_BANK_BITS` and 2^`CHR_BANK_BITS`. The last and second-last PRG banks are all-ones and all-ones minus one at that width.
- R7: `mirror_out` always equals `mirror_cfg`, whatever is written, and `irq` is always 0.
- R8: Reset clears bank-select and all bank bytes. The fixed PRG windows and the forced upper-half bit apply straight away.
- R9: `snap_out` is {R7,…,R0, 2'b00, bank-select[5:0]}, with bank-select in bits 7:0. A high `snap_load` loads all nine bytes from `snap_in` in the same layout (bank-select takes bits 5:0) at the next edge. A load takes priority over a CPU write in the same cycle.
- R10: A register write changes the translation only after the clock edge that samples the strobe. Address translation follows address changes with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address, used for writes and PRG translation |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe |
| ppu_addr | input | 13 | PPU pattern-table address |
| mirror_cfg | input | 1 | Static mirroring setting from the cartridge configuration |
| snap_load | input | 1 | Load all registers from `snap_in` |
| snap_in | input | 72 | Register image to load |
| prg_rom_addr | output | PRG_BANK_BITS+13 | Program ROM address |
| chr_rom_addr | output | CHR_BANK_BITS+10 | Character ROM address |
| mirror_out | output | 1 | Mirroring flag |
| irq | output | 1 | Interrupt request, held low |
| snap_out | output | 72 | Current register image |

## Verification
The bench builds two copies of the block that share all inputs. The first uses the defaults (64 PRG banks, 128 CHR banks), so bank 63 and bank 62 are the fixed windows and the OR with 0x40 lands inside the address range. The second uses `PRG_BANK_BITS`=3, so a written R7 of 0xFF wraps to bank 7 and the fixed windows move to banks 6 and 7, which exercises the modulo rule.

// File: rtl/bankmap_pkg.sv
package bankmap_pkg;
    localparam int NREG   = 8;
    localparam int SEL_W  = 6;
    localparam int SNAP_W = 8 * (NREG + 1);
    typedef logic [NREG-1:0][7:0] bank_vec_t;
    typedef enum logic [1:0] {
        WIN_R6   = 2'd0,
        WIN_R7   = 2'd1,
        WIN_NEXT = 2'd2,
        WIN_LAST = 2'd3
    } prg_win_e;
endpackage

// File: rtl/bankmap_regs.sv
module bankmap_regs
    import bankmap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_data,
    input  logic              cpu_wr,
    input  logic              snap_load,
    input  logic [SNAP_W-1:0] snap_in,
    output logic [SNAP_W-1:0] snap_out,
    output bank_vec_t         bank_o
);
    logic [SEL_W-1:0] sel_q;
    logic             hit;

    assign hit = cpu_wr && cpu_addr[15] && !snap_load;

    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (snap_load)
            sel_q <= snap_in[SEL_W-1:0];
        else if (hit && !cpu_addr[0])
            sel_q <= cpu_data[SEL_W-1:0];
    end

    for (genvar g = 0; g < NREG; g++) begin : g_bank
        logic [7:0] q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (snap_load)
                q <= snap_in[8*(g+1) +: 8];
            else if (hit && cpu_addr[0] && (sel_q[2:0] == 3'(g)))
                q <= cpu_data;
        end
        assign bank_o[g] = q;
    end

    assign snap_out = {bank_o, {(8-SEL_W){1'b0}}, sel_q};

    // R1: a data write leaves bank-select untouched
    p_sel_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && cpu_addr[0]) |=> $stable(sel_q));
    // R1: writes below $8000 change nothing
    p_low_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !cpu_addr[15] && !snap_load) |=> $stable(snap_out));
    // R9: a load replaces the whole image
    p_load_image_r9: assert property (@(posedge clk) disable iff (!rst_n)
        snap_load |=> (snap_out[SNAP_W-1:8] == $past(snap_in[SNAP_W-1:8]))
                      && (snap_out[7:0] == {2'b00, $past(snap_in[5:0])}));
endmodule

// File: rtl/bankmap_prg.sv
module bankmap_prg
    import bankmap_pkg::*;
#(
    parameter int PRG_BANK_BITS = 6,
    localparam int PRG_AW = PRG_BANK_BITS + 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [14:0]       cpu_addr,
    input  logic [7:0]        r6_i,
    input  logic [7:0]        r7_i,
    output logic [PRG_AW-1:0] prg_rom_addr
);
    localparam logic [PRG_BANK_BITS-1:0] LAST = '1;
    localparam logic [PRG_BANK_BITS-1:0] NEXT = LAST - 1'b1;

    prg_win_e                 win;
    logic [PRG_BANK_BITS-1:0] bank;

    assign win = prg_win_e'(cpu_addr[14:13]);

    always_comb begin
        unique case (win)
            WIN_R6:   bank = r6_i[PRG_BANK_BITS-1:0];
            WIN_R7:   bank = r7_i[PRG_BANK_BITS-1:0];
            WIN_NEXT: bank = NEXT;
            WIN_LAST: bank = LAST;
            default:  bank = LAST;
        endcase
    end

    assign prg_rom_addr = {bank, cpu_addr[12:0]};

    // R3: the top window always lands on the last bank
    p_fixed_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[14:13] == 2'b11) |-> (prg_rom_addr[PRG_AW-1:13] == LAST));
endmodule

// File: rtl/bankmap_chr.sv
module bankmap_chr
    import bankmap_pkg::*;
#(
    parameter int CHR_BANK_BITS = 7,
    localparam int CHR_AW = CHR_BANK_BITS + 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [12:0]       ppu_addr,
    input  bank_vec_t         bank_i,
    output logic [CHR_AW-1:0] chr_rom_addr
);
    logic [7:0] pair_val;
    logic [7:0] single_val;
    logic [7:0] bank8;

    assign pair_val   = (ppu_addr[11] ? bank_i[1] : bank_i[0]) & 8'h3E;
    assign single_val = bank_i[2 + int'(ppu_addr[11:10])] | 8'h40;

    always_comb begin
        if (ppu_addr[12])
            bank8 = single_val;
        else
            bank8 = pair_val | {7'd0, ppu_addr[10]};
    end

    assign chr_rom_addr = {bank8[CHR_BANK_BITS-1:0], ppu_addr[9:0]};

    if (CHR_BANK_BITS >= 7) begin : g_half_chk
        // R5: upper pattern table always reads the upper CHR half
        p_upper_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ppu_addr[12] |-> chr_rom_addr[16]);
        // R4: lower pattern table always reads the lower CHR half
        p_lower_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !ppu_addr[12] |-> !chr_rom_addr[16]);
    end
endmodule

// File: rtl/bankmap_top.sv
module bankmap_top
    import bankmap_pkg::*;
#(
    parameter int PRG_BANK_BITS = 6,
    parameter int CHR_BANK_BITS = 7,
    localparam int PRG_AW = PRG_BANK_BITS + 13,
    localparam int CHR_AW = CHR_BANK_BITS + 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_data,
    input  logic              cpu_wr,
    input  logic [12:0]       ppu_addr,
    input  logic              mirror_cfg,
    input  logic              snap_load,
    input  logic [71:0]       snap_in,
    output logic [PRG_AW-1:0] prg_rom_addr,
    output logic [CHR_AW-1:0] chr_rom_addr,
    output logic              mirror_out,
    output logic              irq,
    output logic [71:0]       snap_out
);
    bank_vec_t banks;

    bankmap_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_addr  (cpu_addr),
        .cpu_data  (cpu_data),
        .cpu_wr    (cpu_wr),
        .snap_load (snap_load),
        .snap_in   (snap_in),
        .snap_out  (snap_out),
        .bank_o    (banks)
    );

    bankmap_prg #(.PRG_BANK_BITS(PRG_BANK_BITS)) u_prg (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_addr     (cpu_addr[14:0]),
        .r6_i         (banks[6]),
        .r7_i         (banks[7]),
        .prg_rom_addr (prg_rom_addr)
    );

    bankmap_chr #(.CHR_BANK_BITS(CHR_BANK_BITS)) u_chr (
        .clk          (clk),
        .rst_n        (rst_n),
        .ppu_addr     (ppu_addr),
        .bank_i       (banks),
        .chr_rom_addr (chr_rom_addr)
    );

    assign mirror_out = mirror_cfg;
    assign irq        = 1'b0;
endmodule

// File: tb/bankmap_top_tb.sv
module bankmap_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic        cpu_wr = 1'b0;
    logic [12:0] ppu_addr = '0;
    logic        mirror_cfg = 1'b0;
    logic        snap_load = 1'b0;
    logic [71:0] snap_in = '0;
    logic [18:0] prg_a;
    logic [16:0] chr_a;
    logic        mir, irq;
    logic [71:0] snap;
    logic [15:0] prg_s;
    logic [16:0] chr_s;
    logic        mir_s, irq_s;
    logic [71:0] snap_s;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    bankmap_top u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_wr(cpu_wr), .ppu_addr(ppu_addr), .mirror_cfg(mirror_cfg),
        .snap_load(snap_load), .snap_in(snap_in), .prg_rom_addr(prg_a),
        .chr_rom_addr(chr_a), .mirror_out(mir), .irq(irq), .snap_out(snap));

    bankmap_top #(.PRG_BANK_BITS(3)) u_dut_small (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_wr(cpu_wr), .ppu_addr(ppu_addr), .mirror_cfg(mirror_cfg),
        .snap_load(snap_load), .snap_in(snap_in), .prg_rom_addr(prg_s),
        .chr_rom_addr(chr_s), .mirror_out(mir_s), .irq(irq_s), .snap_out(snap_s));

    typedef struct packed {
        logic        is_chr;
        logic [15:0] addr;
        logic [19:0] exp;
        logic [15:0] exp_small;
    } vec_t;

    localparam vec_t TAB [12] = '{
        '{1'b0, 16'h8123, 20'h0A123, 16'hA123},
        '{1'b0, 16'hA456, 20'h7E456, 16'hE456},
        '{1'b0, 16'hC001, 20'h7C001, 16'hC001},
        '{1'b0, 16'hFFFF, 20'h7FFFF, 16'hFFFF},
        '{1'b1, 16'h0000, 20'h01000, 16'h0000},
        '{1'b1, 16'h07FF, 20'h017FF, 16'h0000},
        '{1'b1, 16'h0800, 20'h01800, 16'h0000},
        '{1'b1, 16'h0C10, 20'h01C10, 16'h0000},
        '{1'b1, 16'h1000, 20'h10000, 16'h0000},
        '{1'b1, 16'h1401, 20'h14401, 16'h0000},
        '{1'b1, 16'h1BFF, 20'h1FFFF, 16'h0000},
        '{1'b1, 16'h1C00, 20'h1FC00, 16'h0000}
    };

    task automatic chk(input string tag, input logic [71:0] got, input logic [71:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_data = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R8: reset state and fixed windows
        #2;
        chk("R8 snap", snap, 72'h0);
        cpu_addr = 16'h8000; #1; chk("R8 prg R6", prg_a, 72'h00000);
        cpu_addr = 16'hC000; #1; chk("R8 prg second-last", prg_a, 72'h7C000);
        ppu_addr = 13'h1000; #1; chk("R8 chr forced bit", chr_a, 72'h10000);
        ppu_addr = 13'h0400; #1; chk("R8 chr pair", chr_a, 72'h00400);
        // R1: program via varied addresses
        wr(16'h8000, 8'h00); wr(16'hE001, 8'hC5);
        wr(16'hA002, 8'h81); wr(16'h9FFF, 8'h07);
        wr(16'hC004, 8'h02); wr(16'h8001, 8'h00);
        wr(16'h8000, 8'h03); wr(16'hB003, 8'h11);
        wr(16'h8000, 8'h04); wr(16'h8001, 8'h3F);
        wr(16'h8000, 8'h05); wr(16'h8001, 8'hFF);
        wr(16'h8000, 8'hC6);
        #2; chk("R2 select top bits dropped", snap[7:0], 72'h06);
        wr(16'hFFFF, 8'h05);
        wr(16'h8000, 8'h07); wr(16'h8001, 8'hFF);
        // R1: writes below $8000 ignored
        wr(16'h7FFF, 8'h99); wr(16'h0000, 8'h99);
        #2; chk("R1 image", snap, 72'hFF_05_FF_3F_11_00_07_C5_07);
        // R3 R4 R5 R6 R2: table walk
        for (int i = 0; i < 12; i++) begin
            if (TAB[i].is_chr) begin
                ppu_addr = TAB[i].addr[12:0]; #1;
                chk($sformatf("R4/R5 chr vec %0d", i), chr_a, 72'(TAB[i].exp));
            end else begin
                cpu_addr = TAB[i].addr; #1;
                chk($sformatf("R3 prg vec %0d", i), prg_a, 72'(TAB[i].exp));
                chk($sformatf("R6 small prg vec %0d", i), prg_s, 72'(TAB[i].exp_small));
            end
        end
        // R10: write visible only after the edge
        wr(16'h8000, 8'h06);
        @(negedge clk);
        cpu_addr = 16'h8001; cpu_data = 8'h09; cpu_wr = 1'b1;
        #5; chk("R10 before edge", prg_a, 72'h0A001);
        @(negedge clk); cpu_wr = 1'b0;
        #2; chk("R10 after edge", prg_a, 72'h12001);
        // R7: mirroring and interrupt
        mirror_cfg = 1'b1;
        wr(16'hA000, 8'h01); wr(16'hC000, 8'h05); wr(16'hE000, 8'h00);
        #2; chk("R7 mirror high", mir, 72'h1);
        mirror_cfg = 1'b0; #1; chk("R7 mirror low", mir, 72'h0);
        chk("R7 irq", irq, 72'h0);
        // R9: load wins over simultaneous write
        @(negedge clk);
        snap_in = 72'h02_01_0A_0C_0B_09_02_08_C3; snap_load = 1'b1;
        cpu_addr = 16'h8001; cpu_data = 8'h77; cpu_wr = 1'b1;
        @(negedge clk);
        snap_load = 1'b0; cpu_wr = 1'b0;
        #2; chk("R9 image", snap, 72'h02_01_0A_0C_0B_09_02_08_03);
        ppu_addr = 13'h0000; #1; chk("R9 chr R0", chr_a, 72'h02000);
        ppu_addr = 13'h1400; #1; chk("R9 chr R3", chr_a, 72'h12C00);
        cpu_addr = 16'h8000; #1; chk("R9 prg R6", prg_a, 72'h02000);
        // R8: reset again mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        #2; chk("R8 re-reset", snap, 72'h0);
        finish_run();
    end
endmodule